// File: doc/BRIEF.md
# Memory-Mapped Stream Link Bridge

The bridge lets a processor talk to a coprocessor over two one-way streaming links using plain loads and stores. On the processor side it has a word-wide register bus with an address, a write enable, a read enable, write data and combinational read data. On the coprocessor side it has two links. The outbound link offers a word with an exists flag and takes a read acknowledge. The inbound link accepts a word with a write strobe and reports a full flag.

Software stores a word at the outbound address to hand it to the coprocessor. It polls the status address until bit 0 reads 1, then loads the inbound data address to collect the result. Each link side holds exactly one entry. Both sides keep the exists/read and full/write handshake exactly, so a coprocessor proven against this bridge also works against a true dedicated link.

Top module: `mmio_stream_bridge`

## Requirements
- R1: A bus write to 0x80000000 drives the written word on `cp_tx_data` from the next cycle, with `cp_tx_exists` high from the next cycle.
- R2: `cp_tx_exists` falls on the cycle after the coprocessor asserts `cp_tx_read` while exists is high and no bus write to 0x80000000 occurs. An asserted `cp_tx_read` while exists is low has no effect.
- R3: A bus write to 0x80000000 while exists is high replaces the pending word and keeps exists high. No earlier word is delivered.
- R4: When `cp_rx_write` is high and `cp_rx_full` is low, the word is captured. From the next cycle `cp_rx_full` is 1 and a bus read of 0x80000004 returns that word.
- R5: A coprocessor write while `cp_rx_full` is high is ignored, and the held word is unchanged.
- R6: A bus read of 0x80000004 clears `cp_rx_full` and the status on the following cycle. The same word is still returned by later reads of 0x80000004 until a new token is captured.
- R7: A bus read of 0x80000008 returns 1 in bit 0 while an unread inbound token is held and 0 otherwise. All other bits read 0.
- R8: Bus reads of any address other than 0x80000004 and 0x80000008 return zero, including 0x80000000. `bus_rdata` is zero while `bus_rd` is low. Bus writes to any address other than 0x80000000 have no effect.
- R9: A synchronous active-high `rst` clears exists, full and status, and sets both held words to zero.
- R10: A coprocessor that takes a word in one cycle and writes it back in the next completes a round trip that software observes through status polling and a data read, for successive tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 32 | Bus address |
| bus_wr | input | 1 | Bus write enable |
| bus_rd | input | 1 | Bus read enable |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational |
| cp_tx_data | output | 32 | Outbound word to the coprocessor |
| cp_tx_exists | output | 1 | Outbound word is pending |
| cp_tx_read | input | 1 | Coprocessor takes the outbound word |
| cp_rx_data | input | 32 | Inbound word from the coprocessor |
| cp_rx_write | input | 1 | Coprocessor writes an inbound word |
| cp_rx_full | output | 1 | Inbound entry is occupied |

## Verification
A wrong outbound state is visible on `cp_tx_exists` or `cp_tx_data` one cycle after the bus write or read acknowledge that should have changed it. A stuck or lost inbound entry is visible on `cp_rx_full` in the cycle after the coprocessor write or bus data read, and on the next status or data read. Overwrite, ignored-write and unmapped-access cases are checked in the cycle right after the stimulus, before any later access can hide the error.

// File: rtl/msb_pkg.sv
package msb_pkg;
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_TX   = 2'd1,
        REG_RX   = 2'd2,
        REG_STAT = 2'd3
    } msb_reg_e;
endpackage

// File: rtl/msb_decode.sv
module msb_decode
    import msb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] TX_ADDR   = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] RX_ADDR   = 32'h8000_0004,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h8000_0008
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output msb_reg_e          hit,
    output logic              tx_push,
    output logic              rx_pop
);
    always_comb begin
        if (addr == TX_ADDR)        hit = REG_TX;
        else if (addr == RX_ADDR)   hit = REG_RX;
        else if (addr == STAT_ADDR) hit = REG_STAT;
        else                        hit = REG_NONE;
        tx_push = wr && (hit == REG_TX);
        rx_pop  = rd && (hit == REG_RX);
    end
endmodule

// File: rtl/msb_tx_slot.sv
module msb_tx_slot #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              take,
    output logic [DATA_W-1:0] word,
    output logic              exists
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              busy;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.word = push_data;
            st_d.busy = 1'b1;
        end else if (st_q.busy && take) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word   = st_q.word;
    assign exists = st_q.busy;

    // R1 and R3: a store lands next cycle and keeps exists high
    assert_tx_load_R1: assert property (@(posedge clk) disable iff (rst)
        push |=> (exists && word == $past(push_data)));
    // R2: acknowledge drops exists
    assert_tx_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (exists && take && !push) |=> !exists);
    // R2: idle slot stays idle and unchanged
    assert_tx_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!exists && !push) |=> (!exists && $stable(word)));
endmodule

// File: rtl/msb_rx_slot.sv
module msb_rx_slot #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  logic              pop,
    output logic [DATA_W-1:0] word,
    output logic              full
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              held;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop) st_d.held = 1'b0;
        if (put && !st_q.held) begin
            st_d.word = put_data;
            st_d.held = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word = st_q.word;
    assign full = st_q.held;

    // R4: capture into an empty entry
    assert_rx_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (put && !full) |=> (full && word == $past(put_data)));
    // R5: writes into an occupied entry are dropped
    assert_rx_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> (full && $stable(word)));
    // R6: a data read frees the entry and keeps the word
    assert_rx_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (full && pop) |=> (!full && $stable(word)));
endmodule

// File: rtl/mmio_stream_bridge.sv
module mmio_stream_bridge
    import msb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] TX_ADDR   = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] RX_ADDR   = 32'h8000_0004,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h8000_0008
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] cp_tx_data,
    output logic              cp_tx_exists,
    input  logic              cp_tx_read,
    input  logic [DATA_W-1:0] cp_rx_data,
    input  logic              cp_rx_write,
    output logic              cp_rx_full
);
    msb_reg_e          hit;
    logic              tx_push;
    logic              rx_pop;
    logic [DATA_W-1:0] rx_word;

    msb_decode #(
        .ADDR_W(ADDR_W), .TX_ADDR(TX_ADDR), .RX_ADDR(RX_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .hit(hit), .tx_push(tx_push), .rx_pop(rx_pop)
    );

    msb_tx_slot #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .push(tx_push), .push_data(bus_wdata),
        .take(cp_tx_read), .word(cp_tx_data), .exists(cp_tx_exists)
    );

    msb_rx_slot #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst(rst), .put(cp_rx_write), .put_data(cp_rx_data),
        .pop(rx_pop), .word(rx_word), .full(cp_rx_full)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (hit)
                REG_RX:   bus_rdata = rx_word;
                REG_STAT: bus_rdata = DATA_W'(cp_rx_full);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R8: reads outside the two readable addresses return zero
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd || (bus_addr != RX_ADDR && bus_addr != STAT_ADDR)) |-> (bus_rdata == '0));
    // R7: status carries only bit 0
    assert_status_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == STAT_ADDR) |-> (bus_rdata[DATA_W-1:1] == '0));
    // R8: a store elsewhere does not arm the outbound link
    assert_stray_write_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != TX_ADDR && !cp_tx_exists) |=> !cp_tx_exists);
endmodule

// File: tb/mmio_stream_bridge_bench.sv
module mmio_stream_bridge_bench;
    localparam logic [31:0] A_TX   = 32'h8000_0000;
    localparam logic [31:0] A_RX   = 32'h8000_0004;
    localparam logic [31:0] A_STAT = 32'h8000_0008;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] cp_tx_data;
    logic        cp_tx_exists;
    logic        cp_tx_read;
    logic [31:0] cp_rx_data;
    logic        cp_rx_write;
    logic        cp_rx_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mmio_stream_bridge u_mmio_stream_bridge (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cp_tx_data(cp_tx_data),
        .cp_tx_exists(cp_tx_exists), .cp_tx_read(cp_tx_read), .cp_rx_data(cp_rx_data),
        .cp_rx_write(cp_rx_write), .cp_rx_full(cp_rx_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cp_take();
        @(negedge clk);
        cp_tx_read = 1'b1;
        @(negedge clk);
        cp_tx_read = 1'b0;
    endtask

    task automatic cp_put(input logic [31:0] d);
        @(negedge clk);
        cp_rx_data = d; cp_rx_write = 1'b1;
        @(negedge clk);
        cp_rx_write = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        chk("R9 exists after reset", 32'(cp_tx_exists), 32'd0);
        chk("R9 full after reset", 32'(cp_rx_full), 32'd0);
        chk("R9 tx word after reset", cp_tx_data, 32'd0);
        bus_read(A_STAT, v);
        chk("R7 status empty", v, 32'd0);
        bus_read(A_RX, v);
        chk("R9 rx word after reset", v, 32'd0);
    endtask

    task automatic t_outbound();
        bus_write(A_TX, 32'hA5A5_0001);
        chk("R1 exists after store", 32'(cp_tx_exists), 32'd1);
        chk("R1 word after store", cp_tx_data, 32'hA5A5_0001);
        cp_take();
        chk("R2 exists after take", 32'(cp_tx_exists), 32'd0);
        cp_take();
        chk("R2 take while idle", 32'(cp_tx_exists), 32'd0);
        chk("R2 word kept while idle", cp_tx_data, 32'hA5A5_0001);
    endtask

    task automatic t_overwrite();
        bus_write(A_TX, 32'h1111_2222);
        bus_write(A_TX, 32'h3333_4444);
        chk("R3 exists after overwrite", 32'(cp_tx_exists), 32'd1);
        chk("R3 word after overwrite", cp_tx_data, 32'h3333_4444);
        cp_take();
        chk("R3 single delivery", 32'(cp_tx_exists), 32'd0);
    endtask

    task automatic t_inbound();
        logic [31:0] v;
        cp_put(32'hDEAD_0001);
        chk("R4 full after put", 32'(cp_rx_full), 32'd1);
        bus_read(A_STAT, v);
        chk("R7 status waiting", v, 32'd1);
        cp_put(32'hDEAD_0002);
        chk("R5 full kept", 32'(cp_rx_full), 32'd1);
        bus_read(A_RX, v);
        chk("R4 R5 first word held", v, 32'hDEAD_0001);
        chk("R6 full cleared", 32'(cp_rx_full), 32'd0);
        bus_read(A_STAT, v);
        chk("R6 status cleared", v, 32'd0);
        bus_read(A_RX, v);
        chk("R6 word still readable", v, 32'hDEAD_0001);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(32'h8000_000C, 32'hFFFF_FFFF);
        chk("R8 stray write no exists", 32'(cp_tx_exists), 32'd0);
        chk("R8 stray write no word", cp_tx_data, 32'h3333_4444);
        bus_write(A_STAT, 32'h0000_0001);
        chk("R8 status not writable", 32'(cp_rx_full), 32'd0);
        bus_read(32'h8000_000C, v);
        chk("R8 unmapped read", v, 32'd0);
        bus_read(A_TX, v);
        chk("R8 outbound address read", v, 32'd0);
        #1 chk("R8 idle rdata", bus_rdata, 32'd0);
    endtask

    task automatic t_copy_loop();
        logic [31:0] v;
        logic [31:0] got;
        for (int i = 0; i < 4; i++) begin
            bus_write(A_TX, 32'h0100_0000 + 32'(i) * 7);
            got = cp_tx_data;
            cp_tx_read = 1'b1;
            @(negedge clk);
            cp_tx_read = 1'b0;
            cp_rx_data = got; cp_rx_write = 1'b1;
            @(negedge clk);
            cp_rx_write = 1'b0;
            v = 0;
            for (int p = 0; p < 8 && v != 1; p++) bus_read(A_STAT, v);
            chk("R10 token ready", v, 32'd1);
            bus_read(A_RX, v);
            chk("R10 round trip word", v, 32'h0100_0000 + 32'(i) * 7);
        end
    endtask

    task automatic t_mid_reset();
        bus_write(A_TX, 32'h7777_0000);
        cp_put(32'h8888_0000);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 exists cleared", 32'(cp_tx_exists), 32'd0);
        chk("R9 full cleared", 32'(cp_rx_full), 32'd0);
        chk("R9 tx word cleared", cp_tx_data, 32'd0);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        cp_tx_read = 1'b0; cp_rx_data = '0; cp_rx_write = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_outbound();
        t_overwrite();
        t_inbound();
        t_unmapped();
        t_copy_loop();
        t_mid_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule